// File: doc/BRIEF.md
# MSI Capability Register Block

This block holds the message-signalled interrupt capability registers found in a device's configuration space. Configuration writes arrive as a byte offset, a width select (16 or 32 bits) and data. The block keeps the control word, the message address (low word, and a high word when 64-bit addressing is supported), the message data and the per-vector mask word. Two build parameters decide whether 64-bit addressing and per-vector masking are present. These two choices move the data and mask registers to different offsets.

The interrupt logic around the block reads back what it needs. It gets the enable state, the number of vectors software has granted, the mask state of a selected vector, the 64-bit message address and the 16-bit message data. It also gets the capability length in bytes. Three single-cycle strobes tell it to program, tear down or refresh its interrupt routes: enable, disable and refresh. Sending the message write on the bus and tracking pending bits are outside the block.

Top module: `msi_cap_regs`

## Requirements
- R1: After reset the enable bit and the granted-vector field read 0. The address, data and mask registers read 0. Control bits [3:1], [7] and [8] hold the parameters CAP_MMC, CAP_64BIT and CAP_PERVEC. A read at offset 0x0 returns the control word in bits 31:16 and zero in bits 15:0.
- R2: Control layout: bit 0 is enable, bits 6:4 are the granted-vector field, bits 15:9 are reserved and read 0. Writes change only bits 0 and 6:4. A 16-bit write at 0x2 takes the control value from data bits 15:0. A 32-bit write at 0x0 takes it from data bits 31:16.
- R3: A 32-bit write at 0x4 stores the low address with bits 1:0 forced to 0.
- R4: With 64-bit addressing, the high address is at 0x8, the data at 0xC and the mask at 0x10. The high address appears on bits 63:32 of the message address.
- R5: Without 64-bit addressing, the data is at 0x8 and the mask at 0xC, and the high address reads 0. The mask register exists only with per-vector masking. Otherwise writes to it are dropped and it reads 0.
- R6: A 16-bit write may target only the control or data offsets. A 32-bit write may target 0x0, 0x4, the data, high-address or mask offsets. Any other combination changes no register.
- R7: The vector count is 2 raised to the granted-vector field when the field is 5 or less, and 0 when it is 6 or 7.
- R8: The selected vector reads as masked only when per-vector masking is present and mask bit vec_sel is 1.
- R9: The capability size is 10 bytes, plus 4 with 64-bit addressing, plus 10 with per-vector masking.
- R10: A control write that takes enable from 0 to 1 raises route_enable_pulse for one cycle. A write that takes it from 1 to 0 raises route_disable_pulse for one cycle. Each strobe is high in the cycle after the write, together with the new enable state. Rewriting the same enable value raises neither strobe.
- R11: Any write strobe, whether or not its offset is accepted, raises cfg_refresh_pulse in the next cycle when enable is 1 after that write.
- R12: A 32-bit write to the data offset stores data bits 15:0. The data register reads back as zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write strobe |
| wr_offset | input | 8 | Byte offset of the write |
| wr_wide | input | 1 | 1 = 32-bit write, 0 = 16-bit write |
| wr_data | input | 32 | Write data (16-bit writes use bits 15:0) |
| rd_offset | input | 8 | Dword offset to read |
| rd_data | output | 32 | Read data, combinational |
| vec_sel | input | 5 | Vector index for the mask query |
| msi_enabled | output | 1 | Enable bit |
| vec_count | output | 6 | Number of granted vectors |
| vec_masked | output | 1 | Mask state of vector vec_sel |
| msg_addr | output | 64 | Message address {high, low} |
| msg_data | output | 16 | Message data |
| cap_size | output | 5 | Capability length in bytes |
| route_enable_pulse | output | 1 | Enable went 0 to 1 |
| route_disable_pulse | output | 1 | Enable went 1 to 0 |
| cfg_refresh_pulse | output | 1 | Write seen while enabled |

## Verification
The hardest case to reach is the offset that changes meaning with the build parameters. Offset 0xC is the data register in one layout and the mask register in the other. A 16-bit write there must be taken by one build and dropped by the other. The bench drives one write stream into two instances, a full 64-bit/masking build and a lean 32-bit build without masking. Each offset write is then compared across both builds in the same cycle. A second hard case is a write the block ignores that still has to raise the refresh strobe while enabled. That case is reached by sending bad offsets and bad widths after enabling.

// File: rtl/msi_cap_pkg.sv
// Package: shared definitions for the MSI capability register block.
// Assumes: control word is 16 bits; mask word width sets the vector limit.
package msi_cap_pkg;

    // Register targeted by an offset/width pair
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTL,
        SEL_ADDR_LO,
        SEL_ADDR_HI,
        SEL_DATA,
        SEL_MASK
    } reg_sel_e;

    // Control word bit positions
    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_MMC_LSB  = 1;
    localparam int CTL_MME_LSB  = 4;
    localparam int CTL_A64_BIT  = 7;
    localparam int CTL_PVM_BIT  = 8;
    localparam int MME_MAX_LOG2 = 5;

endpackage

// File: rtl/msi_offset_map.sv
// Module: msi_offset_map
// Turns an offset and access width into a register select. The data and
// mask offsets depend on the build capability bits.
// Assumes: offsets are byte offsets inside the capability.
module msi_offset_map
    import msi_cap_pkg::*;
#(
    parameter bit CAP_64BIT  = 1'b1,
    parameter bit CAP_PERVEC = 1'b1,
    parameter int OFFS_W     = 8
) (
    input  logic [OFFS_W-1:0] offset,
    input  logic              wide,
    output reg_sel_e          sel
);
    localparam logic [OFFS_W-1:0] OFF_CTL32 = OFFS_W'(8'h00);
    localparam logic [OFFS_W-1:0] OFF_CTL16 = OFFS_W'(8'h02);
    localparam logic [OFFS_W-1:0] OFF_LO    = OFFS_W'(8'h04);
    localparam logic [OFFS_W-1:0] OFF_HI    = OFFS_W'(8'h08);
    localparam logic [OFFS_W-1:0] OFF_DATA  = CAP_64BIT ? OFFS_W'(8'h0C) : OFFS_W'(8'h08);
    localparam logic [OFFS_W-1:0] OFF_MASK  = CAP_64BIT ? OFFS_W'(8'h10) : OFFS_W'(8'h0C);

    // Purpose: pick the target register for this offset and width
    always_comb begin
        sel = SEL_NONE;
        if (!wide) begin
            if (offset == OFF_CTL16)     sel = SEL_CTL;
            else if (offset == OFF_DATA) sel = SEL_DATA;
        end else begin
            if (offset == OFF_CTL32)                  sel = SEL_CTL;
            else if (offset == OFF_LO)                sel = SEL_ADDR_LO;
            else if (offset == OFF_DATA)              sel = SEL_DATA;
            else if (CAP_64BIT && offset == OFF_HI)   sel = SEL_ADDR_HI;
            else if (CAP_PERVEC && offset == OFF_MASK) sel = SEL_MASK;
        end
    end
endmodule

// File: rtl/msi_ctl_reg.sv
// Module: msi_ctl_reg
// Holds the control word. Only enable and the granted-vector field can be
// written. It also produces the route enable/disable/refresh strobes.
// Assumes: ctl_val is already taken from the correct data half.
module msi_ctl_reg
    import msi_cap_pkg::*;
#(
    parameter bit       CAP_64BIT  = 1'b1,
    parameter bit       CAP_PERVEC = 1'b1,
    parameter bit [2:0] CAP_MMC    = 3'd5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_any,
    input  logic        wr_hit,
    input  logic [15:0] ctl_val,
    output logic [15:0] ctl_word,
    output logic        en,
    output logic [2:0]  mme,
    output logic        en_pulse,
    output logic        dis_pulse,
    output logic        refresh_pulse
);
    logic en_q, en_next;
    logic [2:0] mme_q;
    logic [15:0] val_masked;

    // Purpose: keep only the writable bits of the incoming control value
    assign val_masked = ctl_val & 16'h0071;

    // Purpose: enable value after the current write
    assign en_next = wr_hit ? val_masked[CTL_EN_BIT] : en_q;

    // Purpose: control state and one-cycle route strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q          <= 1'b0;
            mme_q         <= 3'd0;
            en_pulse      <= 1'b0;
            dis_pulse     <= 1'b0;
            refresh_pulse <= 1'b0;
        end else begin
            if (wr_hit) begin
                en_q  <= val_masked[CTL_EN_BIT];
                mme_q <= val_masked[CTL_MME_LSB +: 3];
            end
            en_pulse      <= wr_hit &  en_next & ~en_q;
            dis_pulse     <= wr_hit & ~en_next &  en_q;
            refresh_pulse <= wr_any &  en_next;
        end
    end

    // Purpose: assemble the readable control word
    always_comb begin
        ctl_word = '0;
        ctl_word[CTL_EN_BIT]          = en_q;
        ctl_word[CTL_MMC_LSB +: 3]    = CAP_MMC;
        ctl_word[CTL_MME_LSB +: 3]    = mme_q;
        ctl_word[CTL_A64_BIT]         = CAP_64BIT;
        ctl_word[CTL_PVM_BIT]         = CAP_PERVEC;
    end

    assign en  = en_q;
    assign mme = mme_q;
endmodule

// File: rtl/msi_vector_view.sv
// Module: msi_vector_view
// Derives the granted-vector count, the mask state of one vector and the
// capability length from the stored registers.
// Assumes: mask is zero when per-vector masking is absent.
module msi_vector_view
    import msi_cap_pkg::*;
#(
    parameter bit CAP_64BIT  = 1'b1,
    parameter bit CAP_PERVEC = 1'b1,
    parameter int MASK_W     = 32,
    parameter int SEL_W      = $clog2(MASK_W),
    parameter int CNT_W      = SEL_W + 1
) (
    input  logic [2:0]        mme,
    input  logic [MASK_W-1:0] mask,
    input  logic [SEL_W-1:0]  vec_sel,
    output logic [CNT_W-1:0]  vec_count,
    output logic              vec_masked,
    output logic [4:0]        cap_size
);
    localparam int SIZE_BASE = 10;
    localparam int SIZE_A64  = CAP_64BIT  ? 4  : 0;
    localparam int SIZE_PVM  = CAP_PERVEC ? 10 : 0;

    // Purpose: 2^field for legal fields, zero for the two reserved codes
    always_comb begin
        if (int'(mme) > MME_MAX_LOG2) vec_count = '0;
        else                          vec_count = CNT_W'(1) << mme;
    end

    // Purpose: per-vector mask lookup, only when masking is built in
    assign vec_masked = CAP_PERVEC && mask[vec_sel];

    // Purpose: capability length from the build options
    assign cap_size = 5'(SIZE_BASE + SIZE_A64 + SIZE_PVM);
endmodule

// File: rtl/msi_cap_regs.sv
// Module: msi_cap_regs (top)
// MSI capability register set. It decodes configuration writes, stores the
// address/data/mask registers and serves combinational reads.
// Assumes: one write per cycle at most; reads are dword aligned.
module msi_cap_regs
    import msi_cap_pkg::*;
#(
    parameter bit       CAP_64BIT  = 1'b1,
    parameter bit       CAP_PERVEC = 1'b1,
    parameter bit [2:0] CAP_MMC    = 3'd5,
    parameter int       OFFS_W     = 8,
    parameter int       MASK_W     = 32,
    parameter int       SEL_W      = $clog2(MASK_W),
    parameter int       CNT_W      = SEL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [OFFS_W-1:0] wr_offset,
    input  logic              wr_wide,
    input  logic [31:0]       wr_data,
    input  logic [OFFS_W-1:0] rd_offset,
    output logic [31:0]       rd_data,
    input  logic [SEL_W-1:0]  vec_sel,
    output logic              msi_enabled,
    output logic [CNT_W-1:0]  vec_count,
    output logic              vec_masked,
    output logic [63:0]       msg_addr,
    output logic [15:0]       msg_data,
    output logic [4:0]        cap_size,
    output logic              route_enable_pulse,
    output logic              route_disable_pulse,
    output logic              cfg_refresh_pulse
);
    reg_sel_e    wsel, rsel;
    logic [15:0] ctl_word, ctl_val;
    logic [2:0]  mme;
    logic [31:0] addr_lo_q, addr_hi_q;
    logic [15:0] data_q;
    logic [MASK_W-1:0] mask_q;

    msi_offset_map #(.CAP_64BIT(CAP_64BIT), .CAP_PERVEC(CAP_PERVEC), .OFFS_W(OFFS_W))
        u_wmap (.offset(wr_offset), .wide(wr_wide), .sel(wsel));

    msi_offset_map #(.CAP_64BIT(CAP_64BIT), .CAP_PERVEC(CAP_PERVEC), .OFFS_W(OFFS_W))
        u_rmap (.offset(rd_offset), .wide(1'b1), .sel(rsel));

    // Purpose: control value comes from the upper half on 32-bit writes
    assign ctl_val = wr_wide ? wr_data[31:16] : wr_data[15:0];

    msi_ctl_reg #(.CAP_64BIT(CAP_64BIT), .CAP_PERVEC(CAP_PERVEC), .CAP_MMC(CAP_MMC))
        u_ctl (
            .clk(clk), .rst_n(rst_n),
            .wr_any(wr_valid), .wr_hit(wr_valid && wsel == SEL_CTL),
            .ctl_val(ctl_val), .ctl_word(ctl_word),
            .en(msi_enabled), .mme(mme),
            .en_pulse(route_enable_pulse), .dis_pulse(route_disable_pulse),
            .refresh_pulse(cfg_refresh_pulse)
        );

    // Purpose: low address and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo_q <= '0;
            data_q    <= '0;
        end else if (wr_valid) begin
            if (wsel == SEL_ADDR_LO) addr_lo_q <= {wr_data[31:2], 2'b00};
            if (wsel == SEL_DATA)    data_q    <= wr_data[15:0];
        end
    end

    generate
        if (CAP_64BIT) begin : g_hi
            // Purpose: upper address register for 64-bit builds
            always_ff @(posedge clk) begin
                if (!rst_n)                                addr_hi_q <= '0;
                else if (wr_valid && wsel == SEL_ADDR_HI)  addr_hi_q <= wr_data;
            end
        end else begin : g_no_hi
            assign addr_hi_q = '0;
        end

        if (CAP_PERVEC) begin : g_mask
            // Purpose: per-vector mask register
            always_ff @(posedge clk) begin
                if (!rst_n)                             mask_q <= '0;
                else if (wr_valid && wsel == SEL_MASK)  mask_q <= MASK_W'(wr_data);
            end
        end else begin : g_no_mask
            assign mask_q = '0;
        end
    endgenerate

    msi_vector_view #(.CAP_64BIT(CAP_64BIT), .CAP_PERVEC(CAP_PERVEC), .MASK_W(MASK_W),
                      .SEL_W(SEL_W), .CNT_W(CNT_W))
        u_view (.mme(mme), .mask(mask_q), .vec_sel(vec_sel),
                .vec_count(vec_count), .vec_masked(vec_masked), .cap_size(cap_size));

    // Purpose: read multiplexer, unmapped offsets read zero
    always_comb begin
        case (rsel)
            SEL_CTL:     rd_data = {ctl_word, 16'h0000};
            SEL_ADDR_LO: rd_data = addr_lo_q;
            SEL_ADDR_HI: rd_data = addr_hi_q;
            SEL_DATA:    rd_data = {16'h0000, data_q};
            SEL_MASK:    rd_data = 32'(mask_q);
            default:     rd_data = '0;
        endcase
    end

    assign msg_addr = {addr_hi_q, addr_lo_q};
    assign msg_data = data_q;
endmodule

// File: rtl/msi_cap_regs_checker.sv
// Module: msi_cap_regs_checker
// Concurrent checks on the strobes and outputs of msi_cap_regs. It is
// attached to every instance by the bind below.
// Assumes: rst_n is held low over the first clock edge.
module msi_cap_regs_checker #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             msi_enabled,
    input logic             route_enable_pulse,
    input logic             route_disable_pulse,
    input logic             cfg_refresh_pulse,
    input logic [CNT_W-1:0] vec_count,
    input logic [4:0]       cap_size,
    input logic [63:0]      msg_addr
);
    // R10: enable strobe only together with a fresh 0->1 of enable
    a_r10_enable_edge: assert property (@(posedge clk) disable iff (!rst_n)
        route_enable_pulse |-> (msi_enabled && !$past(msi_enabled)));

    // R10: disable strobe only together with a fresh 1->0 of enable
    a_r10_disable_edge: assert property (@(posedge clk) disable iff (!rst_n)
        route_disable_pulse |-> (!msi_enabled && $past(msi_enabled)));

    // R10: enable and disable strobes never coincide
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(route_enable_pulse && route_disable_pulse));

    // R11: refresh strobe only while enabled
    a_r11_refresh_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_refresh_pulse |-> msi_enabled);

    // R7: vector count is zero or a power of two
    a_r7_count_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vec_count) <= 1);

    // R3: message address is always dword aligned
    a_r3_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        msg_addr[1:0] == 2'b00);

    // R9: capability size never changes at run time
    a_r9_size_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cap_size));
endmodule

bind msi_cap_regs msi_cap_regs_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .msi_enabled(msi_enabled),
    .route_enable_pulse(route_enable_pulse), .route_disable_pulse(route_disable_pulse),
    .cfg_refresh_pulse(cfg_refresh_pulse), .vec_count(vec_count),
    .cap_size(cap_size), .msg_addr(msg_addr)
);

// File: tb/msi_cap_regs_bench.sv
// Bench: directed scenarios on a full build (64-bit, masking, MMC=5) and a
// lean build (32-bit, no masking, MMC=2) that share one write stream.
module msi_cap_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_offset = '0;
    logic        wr_wide = 1'b0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_offset = '0;
    logic [4:0]  vec_sel = '0;

    logic [31:0] rd_data, l_rd_data;
    logic        msi_enabled, l_msi_enabled;
    logic [5:0]  vec_count, l_vec_count;
    logic        vec_masked, l_vec_masked;
    logic [63:0] msg_addr, l_msg_addr;
    logic [15:0] msg_data, l_msg_data;
    logic [4:0]  cap_size, l_cap_size;
    logic        p_en, p_dis, p_ref, l_p_en, l_p_dis, l_p_ref;

    logic        s_en, s_dis, s_ref, sl_en, sl_dis, sl_ref;
    int          n_tests = 0;
    int          n_fail  = 0;

    always #2.5 clk = ~clk;

    msi_cap_regs u_msi_cap_regs (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_offset(wr_offset),
        .wr_wide(wr_wide), .wr_data(wr_data), .rd_offset(rd_offset), .rd_data(rd_data),
        .vec_sel(vec_sel), .msi_enabled(msi_enabled), .vec_count(vec_count),
        .vec_masked(vec_masked), .msg_addr(msg_addr), .msg_data(msg_data),
        .cap_size(cap_size), .route_enable_pulse(p_en), .route_disable_pulse(p_dis),
        .cfg_refresh_pulse(p_ref)
    );

    msi_cap_regs #(.CAP_64BIT(1'b0), .CAP_PERVEC(1'b0), .CAP_MMC(3'd2)) u_msi_cap_regs_lean (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_offset(wr_offset),
        .wr_wide(wr_wide), .wr_data(wr_data), .rd_offset(rd_offset), .rd_data(l_rd_data),
        .vec_sel(vec_sel), .msi_enabled(l_msi_enabled), .vec_count(l_vec_count),
        .vec_masked(l_vec_masked), .msg_addr(l_msg_addr), .msg_data(l_msg_data),
        .cap_size(l_cap_size), .route_enable_pulse(l_p_en), .route_disable_pulse(l_p_dis),
        .cfg_refresh_pulse(l_p_ref)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One write; strobes are sampled in the cycle after the capturing edge
    task automatic wr(input logic wide, input logic [7:0] off, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_wide = wide; wr_offset = off; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
        s_en = p_en; s_dis = p_dis; s_ref = p_ref;
        sl_en = l_p_en; sl_dis = l_p_dis; sl_ref = l_p_ref;
    endtask

    task automatic rd(input logic [7:0] off);
        rd_offset = off;
        #1;
    endtask

    task automatic t_reset();
        rd(8'h00);
        check("R1 ctl full",  64'(rd_data),   64'h018A_0000);
        check("R1 ctl lean",  64'(l_rd_data), 64'h0004_0000);
        check("R1 enable",    64'(msi_enabled), 64'd0);
        check("R1 address",   msg_addr, 64'd0);
        check("R1 data",      64'(msg_data), 64'd0);
        rd(8'h10);
        check("R1 mask",      64'(rd_data), 64'd0);
        check("R7 count mme0", 64'(vec_count), 64'd1);
        check("R9 size full", 64'(cap_size), 64'd24);
        check("R9 size lean", 64'(l_cap_size), 64'd10);
    endtask

    task automatic t_ctl();
        wr(1'b0, 8'h02, 32'h0000_FFFF);
        rd(8'h00);
        check("R2 16b ctl full", 64'(rd_data),   64'h01FB_0000);
        check("R2 16b ctl lean", 64'(l_rd_data), 64'h0075_0000);
        check("R10 enable strobe", 64'(s_en), 64'd1);
        check("R10 no disable",    64'(s_dis), 64'd0);
        check("R7 count mme7",     64'(vec_count), 64'd0);
        wr(1'b1, 8'h00, 32'h0030_FFFF);
        rd(8'h00);
        check("R2 32b ctl upper half", 64'(rd_data), 64'h01BA_0000);
        check("R10 disable strobe", 64'(s_dis), 64'd1);
        check("R11 no refresh when disabled", 64'(s_ref), 64'd0);
        check("R7 count mme3", 64'(vec_count), 64'd8);
        wr(1'b0, 8'h02, 32'h0000_0051);
        check("R10 re-enable", 64'(s_en), 64'd1);
        check("R7 count mme5", 64'(vec_count), 64'd32);
        wr(1'b0, 8'h02, 32'h0000_0061);
        check("R10 same enable no strobe", 64'({s_en, s_dis}), 64'd0);
        check("R11 refresh while enabled", 64'(s_ref), 64'd1);
        check("R7 count mme6", 64'(vec_count), 64'd0);
    endtask

    task automatic t_count_sweep();
        for (int m = 0; m < 8; m++) begin
            wr(1'b0, 8'h02, 32'(1 | (m << 4)));
            check("R7 count sweep", 64'(vec_count), (m > 5) ? 64'd0 : 64'(1 << m));
        end
    endtask

    task automatic t_addr();
        wr(1'b1, 8'h04, 32'hDEAD_BEEF);
        check("R3 low address aligned", 64'(msg_addr[31:0]), 64'hDEAD_BEEC);
        wr(1'b1, 8'h08, 32'h1234_5678);
        check("R4 high address", msg_addr, 64'h1234_5678_DEAD_BEEC);
        check("R5 lean 0x8 is data", 64'(l_msg_data), 64'h5678);
        check("R5 lean high zero", l_msg_addr, 64'h0000_0000_DEAD_BEEC);
    endtask

    task automatic t_data();
        wr(1'b0, 8'h0C, 32'h0000_A5A5);
        check("R4 data at 0xC", 64'(msg_data), 64'hA5A5);
        check("R6 lean 16b at 0xC ignored", 64'(l_msg_data), 64'h5678);
        wr(1'b1, 8'h0C, 32'hFFFF_1234);
        check("R12 32b data low half", 64'(msg_data), 64'h1234);
        rd(8'h0C);
        check("R12 data read zero-extended", 64'(rd_data), 64'h0000_1234);
        check("R5 lean mask absent", 64'(l_rd_data), 64'd0);
    endtask

    task automatic t_mask();
        wr(1'b1, 8'h10, 32'h0000_0004);
        rd(8'h10);
        check("R4 mask at 0x10", 64'(rd_data), 64'h4);
        vec_sel = 5'd2; #1;
        check("R8 vector 2 masked", 64'(vec_masked), 64'd1);
        check("R8 lean never masked", 64'(l_vec_masked), 64'd0);
        vec_sel = 5'd3; #1;
        check("R8 vector 3 clear", 64'(vec_masked), 64'd0);
    endtask

    task automatic t_ignored();
        wr(1'b0, 8'h04, 32'h0000_1111);
        check("R6 16b at 0x4 ignored", 64'(msg_addr[31:0]), 64'hDEAD_BEEC);
        check("R11 refresh on ignored write", 64'(s_ref), 64'd1);
        wr(1'b0, 8'h10, 32'h0000_FFFF);
        rd(8'h10);
        check("R6 16b mask ignored", 64'(rd_data), 64'h4);
        wr(1'b1, 8'h14, 32'hFFFF_FFFF);
        check("R6 0x14 ignored", msg_addr, 64'h1234_5678_DEAD_BEEC);
        wr(1'b0, 8'h00, 32'h0000_0000);
        check("R6 16b at 0x0 ignored", 64'({msi_enabled, s_dis}), 64'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctl();
        t_count_sweep();
        t_addr();
        t_data();
        t_mask();
        t_ignored();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule